// File: doc/BRIEF.md
# Run-Length Loss-of-Signal Detector

This block sits behind a deserializer and watches each received parallel word for a line that has stopped toggling. When the incoming stream shows a long stretch of identical bits, either all ones or all zeros, it raises a violation flag. That flag tells the receive lock state machine to abandon the data and pull the recovery loop back onto the reference clock, so a dead or disconnected line is handled within a few words.

The detector works on whole words rather than single bits. A word counts toward a run only when every one of its bits has the same value and that value matches the previous counted word. The flag rises once a preset number of such words arrive back to back. Because a run of bits seldom starts on a word boundary, the shortest run that can trip the flag and the shortest run that is sure to trip it differ by up to one word. With 10-bit words and a 12-word threshold, runs of 119 bits or fewer never trip it, runs of 129 bits or more always do, and runs in between trip it only for some alignments.

A strobe marks which cycles carry a word. Cycles without the strobe leave the detector untouched.

Top module: `run_los_detector`

## Requirements
- R1: While reset is high and in the first cycle after it, the flag is low and the run count is cleared, so a fresh run needs the full number of words.
- R2: A word is uniform when all of its WORD_W bits are equal. Both all-ones (0x3FF) and all-zeros (0x000) words count toward a run.
- R3: The flag goes high in the same cycle in which the RUN_WORDS-th (default 12) consecutive valid uniform word of one polarity is presented.
- R4: With fewer than RUN_WORDS such words the flag stays low, so a run of 119 identical bits at any word alignment never raises it.
- R5: A run of 129 identical bits at any alignment always raises the flag. A run of 120 bits starting on a word boundary raises it, and a run of 120 bits starting one bit later does not.
- R6: Once high, the flag stays high while more uniform words of the same polarity arrive.
- R7: A valid word with mixed bits clears the run. If the flag is high it stays high during that cycle and is low from the next cycle.
- R8: A valid uniform word of the opposite polarity starts a new run with a count of 1. If the flag is high it stays high during that cycle and is low from the next cycle, and RUN_WORDS-1 further words of the new polarity raise it again.
- R9: In a cycle with the word strobe low, the word value is ignored and the count, polarity and flag are held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| word_vld | input | 1 | High when `word` carries a received word |
| word | input | WORD_W | Received parallel word |
| los_flag | output | 1 | Run-length violation, to the lock state machine |

## Verification
The bench builds the detector with its defaults, WORD_W = 10 and RUN_WORDS = 12, so that the bit-count limits of 119, 120 and 129 can be reached directly. Bit-level runs are cut into words at every one of the ten possible alignments, for both polarities. This shows that the word-based count never fires below the guaranteed floor, always fires above the ceiling, and splits at 120 bits depending on phase. The vector table covers the word-level sequencing: saturation, polarity change, mixed words and idle cycles.

// File: rtl/los_pkg.sv
package los_pkg;

    typedef enum logic {
        POL_ZERO = 1'b0,
        POL_ONE  = 1'b1
    } line_pol_e;

    typedef struct packed {
        logic      uniform;
        line_pol_e pol;
    } word_class_t;

    typedef enum logic [1:0] {
        STEP_HOLD,
        STEP_CLEAR,
        STEP_EXTEND,
        STEP_RESTART
    } run_step_e;

    // Choose what the run counter does with the word on offer this cycle.
    function automatic run_step_e decide_step(
        input logic        vld,
        input word_class_t wc,
        input line_pol_e   pol_q,
        input logic        run_empty
    );
        run_step_e s;
        if (!vld) begin
            s = STEP_HOLD;
        end else if (!wc.uniform) begin
            s = STEP_CLEAR;
        end else if (run_empty || (wc.pol == pol_q)) begin
            s = STEP_EXTEND;
        end else begin
            s = STEP_RESTART;
        end
        return s;
    endfunction

endpackage

// File: rtl/los_word_classifier.sv
module los_word_classifier
    import los_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic [WORD_W-1:0] word,
    output word_class_t       wc
);

    logic all_one;
    logic all_zero;

    assign all_one  = &word;
    assign all_zero = ~(|word);

    always_comb begin
        wc.uniform = all_one | all_zero;
        wc.pol     = all_one ? POL_ONE : POL_ZERO;
    end

endmodule

// File: rtl/los_run_counter.sv
module los_run_counter
    import los_pkg::*;
#(
    parameter int RUN_WORDS = 12,
    parameter int CNT_W     = $clog2(RUN_WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vld,
    input  word_class_t      wc,
    output logic [CNT_W-1:0] cnt_q,
    output logic             hit
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_WORDS);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    line_pol_e        pol_q;
    line_pol_e        pol_d;
    logic [CNT_W-1:0] cnt_d;
    run_step_e        step;

    assign step = decide_step(vld, wc, pol_q, (cnt_q == '0));

    always_comb begin
        cnt_d = cnt_q;
        pol_d = pol_q;
        unique case (step)
            STEP_HOLD: begin
                cnt_d = cnt_q;
            end
            STEP_CLEAR: begin
                cnt_d = '0;
            end
            STEP_EXTEND: begin
                cnt_d = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_ONE;
                pol_d = wc.pol;
            end
            STEP_RESTART: begin
                cnt_d = CNT_ONE;
                pol_d = wc.pol;
            end
            default: begin
                cnt_d = cnt_q;
            end
        endcase
    end

    // Threshold reached by the word presented this cycle.
    assign hit = (cnt_d == CNT_MAX) && (cnt_q != CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            pol_q <= POL_ZERO;
        end else begin
            cnt_q <= cnt_d;
            pol_q <= pol_d;
        end
    end

endmodule

// File: rtl/run_los_detector.sv
module run_los_detector
    import los_pkg::*;
#(
    parameter int WORD_W    = 10,
    parameter int RUN_WORDS = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word,
    output logic              los_flag
);

    localparam int CNT_W = $clog2(RUN_WORDS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_WORDS);

    word_class_t      wc;
    logic [CNT_W-1:0] cnt_q;
    logic             hit;

    los_word_classifier #(
        .WORD_W (WORD_W)
    ) u_class (
        .word (word),
        .wc   (wc)
    );

    los_run_counter #(
        .RUN_WORDS (RUN_WORDS),
        .CNT_W     (CNT_W)
    ) u_run (
        .clk   (clk),
        .rst   (rst),
        .vld   (word_vld),
        .wc    (wc),
        .cnt_q (cnt_q),
        .hit   (hit)
    );

    // Saturated count holds the flag; the hit term raises it without delay.
    assign los_flag = (cnt_q == CNT_MAX) | hit;

endmodule

// File: rtl/run_los_checker.sv
module run_los_checker #(
    parameter int WORD_W    = 10,
    parameter int RUN_WORDS = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              word_vld,
    input logic [WORD_W-1:0] word,
    input logic              los_flag
);

    localparam int RW = $clog2(RUN_WORDS + 1);
    localparam logic [RW-1:0] RMAX = RW'(RUN_WORDS);

    logic              uni;
    logic [RW-1:0]     run_q;
    logic [WORD_W-1:0] last_q;
    logic              same;

    assign uni  = (&word) | ~(|word);
    assign same = (run_q != '0) && (word == last_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            last_q <= '0;
        end else if (word_vld) begin
            if (!uni) begin
                run_q <= '0;
            end else if (same) begin
                run_q <= (run_q == RMAX) ? RMAX : run_q + RW'(1);
            end else begin
                run_q  <= RW'(1);
                last_q <= word;
            end
        end
    end

    // R1: flag low in the first cycle after reset
    a_r1_low_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !los_flag);

    // R3: flag rises only on the word that completes the run
    a_r3_rise_on_last_word: assert property (@(posedge clk) disable iff (rst)
        $rose(los_flag) |-> (word_vld && uni && same && run_q == RMAX - RW'(1)));

    // R4: flag never high without a full run behind it
    a_r4_needs_full_run: assert property (@(posedge clk) disable iff (rst)
        los_flag |-> ((run_q == RMAX) ||
                      (word_vld && uni && same && run_q == RMAX - RW'(1))));

    // R7: a mixed word drops the flag from the next cycle
    a_r7_mixed_clears: assert property (@(posedge clk) disable iff (rst)
        (word_vld && !uni) |=> !los_flag);

    // R9: idle cycles keep a raised flag
    a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!word_vld && los_flag) |=> los_flag);

endmodule

bind run_los_detector run_los_checker #(
    .WORD_W    (WORD_W),
    .RUN_WORDS (RUN_WORDS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .word_vld (word_vld),
    .word     (word),
    .los_flag (los_flag)
);

// File: tb/run_los_detector_tb.sv
`timescale 1ns/1ps
module run_los_detector_tb;

    localparam int WORD_W    = 10;
    localparam int RUN_WORDS = 12;
    localparam int NVEC      = 30;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              word_vld = 1'b0;
    logic [WORD_W-1:0] word = '0;
    logic              los_flag;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    run_los_detector #(
        .WORD_W    (WORD_W),
        .RUN_WORDS (RUN_WORDS)
    ) u_dut (
        .clk      (clk),
        .rst      (rst),
        .word_vld (word_vld),
        .word     (word),
        .los_flag (los_flag)
    );

    // Fields: [15:12] requirement, [11] strobe, [10:1] word, [0] expected flag
    localparam logic [15:0] VEC [NVEC] = '{
        {4'd9, 1'b0, 10'h3FF, 1'b0},
        {4'd2, 1'b1, 10'h3FF, 1'b0},
        {4'd4, 1'b1, 10'h3FF, 1'b0},
        {4'd4, 1'b1, 10'h3FF, 1'b0},
        {4'd4, 1'b1, 10'h3FF, 1'b0},
        {4'd4, 1'b1, 10'h3FF, 1'b0},
        {4'd4, 1'b1, 10'h3FF, 1'b0},
        {4'd4, 1'b1, 10'h3FF, 1'b0},
        {4'd4, 1'b1, 10'h3FF, 1'b0},
        {4'd4, 1'b1, 10'h3FF, 1'b0},
        {4'd4, 1'b1, 10'h3FF, 1'b0},
        {4'd4, 1'b1, 10'h3FF, 1'b0},
        {4'd3, 1'b1, 10'h3FF, 1'b1},
        {4'd6, 1'b1, 10'h3FF, 1'b1},
        {4'd9, 1'b0, 10'h155, 1'b1},
        {4'd8, 1'b1, 10'h000, 1'b1},
        {4'd8, 1'b1, 10'h000, 1'b0},
        {4'd8, 1'b1, 10'h000, 1'b0},
        {4'd8, 1'b1, 10'h000, 1'b0},
        {4'd8, 1'b1, 10'h000, 1'b0},
        {4'd8, 1'b1, 10'h000, 1'b0},
        {4'd8, 1'b1, 10'h000, 1'b0},
        {4'd8, 1'b1, 10'h000, 1'b0},
        {4'd8, 1'b1, 10'h000, 1'b0},
        {4'd8, 1'b1, 10'h000, 1'b0},
        {4'd8, 1'b1, 10'h000, 1'b0},
        {4'd8, 1'b1, 10'h000, 1'b1},
        {4'd7, 1'b1, 10'h2AA, 1'b1},
        {4'd7, 1'b1, 10'h000, 1'b0},
        {4'd9, 1'b0, 10'h3FF, 1'b0}
    };

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: los_flag=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive at the falling edge, then let the rising edge accept the word.
    task automatic drive(input logic v, input logic [WORD_W-1:0] w);
        @(negedge clk);
        word_vld = v;
        word     = w;
        #1;
    endtask

    // Present a run of len bits of value pol, starting off bits into a word.
    task automatic send_run(input logic pol, input int len, input int off, output logic seen);
        logic bits [0:219];
        int   nwords;
        seen = 1'b0;
        nwords = (off + len + WORD_W - 1) / WORD_W + 1;
        for (int k = 0; k < 220; k++) begin
            bits[k] = (k >= off && k < off + len) ? pol : ~pol;
        end
        drive(1'b1, 10'h155);
        for (int w = 0; w < nwords; w++) begin
            logic [WORD_W-1:0] wd;
            for (int b = 0; b < WORD_W; b++) wd[b] = bits[w * WORD_W + b];
            drive(1'b1, wd);
            seen |= los_flag;
        end
        drive(1'b1, 10'h155);
    endtask

    initial begin
        logic seen;
        repeat (3) @(negedge clk);
        #1;
        check("R1", los_flag, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][11], VEC[i][10:1]);
            check(req_name(VEC[i][15:12]), los_flag, VEC[i][0]);
        end

        // R1: reset in the middle of a saturated run clears everything
        for (int i = 0; i < RUN_WORDS + 1; i++) drive(1'b1, 10'h3FF);
        check("R6", los_flag, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        word_vld = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", los_flag, 1'b0);
        for (int i = 0; i < RUN_WORDS - 1; i++) drive(1'b1, 10'h3FF);
        check("R1", los_flag, 1'b0);
        drive(1'b1, 10'h3FF);
        check("R3", los_flag, 1'b1);
        drive(1'b1, 10'h1FF);
        drive(1'b0, 10'h000);
        check("R7", los_flag, 1'b0);

        // R4: 119 bits never trip, at every alignment, both polarities
        for (int off = 0; off < WORD_W; off++) begin
            send_run(off[0], 119, off, seen);
            check("R4", seen, 1'b0);
        end
        // R5: 129 bits always trip, at every alignment
        for (int off = 0; off < WORD_W; off++) begin
            send_run(~off[0], 129, off, seen);
            check("R5", seen, 1'b1);
        end
        send_run(1'b1, 120, 0, seen);
        check("R5", seen, 1'b1);
        send_run(1'b0, 120, 1, seen);
        check("R5", seen, 1'b0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule